// File: doc/BRIEF.md
# Strobe-Gated Read Capture

This block sits in the read path of a double-data-rate memory controller and decides which transitions of the returning data strobe count as read data. It runs on the double-rate clock. A read-issue pulse starts a read-latency timer. The timer's setting is counted in double-rate ticks, so each count is half a memory clock. The controller has no notion of the memory's CAS latency. It only needs to know roughly when the memory starts to drive the strobe, and the setting is tuned to the round-trip delay of the board. For example, a setting one count higher adds half a memory cycle for a half-cycle CAS latency or for long traces, and a lower setting suits very short traces.

While the timer runs, every strobe transition is masked, so bus noise and the turnaround of a bidirectional strobe cannot latch false data. After the timer expires, each strobe edge, rising or falling, produces one capture pulse. Once as many edges as the burst length have been counted, the block flags read-done for one cycle and returns to idle. If edges are missed, the block keeps waiting and stays busy. Only a write cycle returns it to idle.

Top module: `dqs_read_gate`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `cap_pulse` and `rd_done` are 0.
- R2: When `rd_issue` is 1 at a clock edge while `busy` is 0 and `wr_active` is 0, the read is accepted and `busy` is 1 in the following cycle.
- R3: Let L be the value of `lat_cfg` at acceptance. Strobe edges visible in the first L cycles after the accepting edge are ignored. Edges visible from cycle L onward are captured, counting the cycle right after the accepting edge as cycle 0. With L = 0 nothing is masked.
- R4: The strobe level is registered once per clock. An edge is visible in the cycle after the clock edge that samples a level different from the previous sample, so both rising and falling transitions count. During the capture phase each visible edge raises `cap_pulse` for exactly that one cycle.
- R5: Let B be the burst length. In the cycle after the B-th captured edge, `rd_done` is 1 for exactly one cycle with `busy` still 1. In the next cycle `busy` is 0. A `burst_len` field of 0 encodes B = 2^BL_W, which is 16 at the default width. Any other field value N encodes B = N.
- R6: If fewer than B edges arrive after the masking window, `busy` stays 1 and `rd_done` stays 0 indefinitely.
- R7: `wr_active` at a clock edge forces the block idle with its counts discarded: `busy` is 0 and `cap_pulse` is 0 in the following cycle. It overrides a simultaneous `rd_issue`.
- R8: `rd_issue` while `busy` is 1 is ignored and leaves the read in progress unchanged.
- R9: `lat_cfg` and `burst_len` are captured at acceptance. Changing them during a read has no effect on that read.
- R10: `cap_pulse` is 0 whenever the block is idle, masking or signalling done, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_issue | input | 1 | One-cycle pulse: a read command was issued |
| wr_active | input | 1 | A write cycle is driving the strobe; clears the read state |
| lat_cfg | input | LAT_W | Read latency in double-rate ticks |
| burst_len | input | BL_W | Strobe edges per read (0 encodes 2^BL_W) |
| dqs_in | input | 1 | Data strobe, synchronous level |
| cap_pulse | output | 1 | Capture one data beat this cycle |
| busy | output | 1 | A read is in progress |
| rd_done | output | 1 | One-cycle pulse: the burst has completed |

## Verification
The assertions check four things on every cycle against an independent window counter and beat counter: no capture pulse inside the latency window, never more pulses than the captured burst length, read-done only after a full burst and followed by idle, and the clearing effect of the write indication. Whether edges are timed exactly to the cycle is shown only by the bench's scenarios. These sweep latency settings, burst lengths and strobe start points against arithmetic expectations. The scenarios also cover the stuck state after a short burst, recovery through a write, and the ignored settings and issue pulses during a read.

// File: rtl/dqs_gate_pkg.sv
package dqs_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } gate_state_e;

endpackage

// File: rtl/dqs_edge_detect.sv
// Registers the strobe level and flags any change between two samples.
module dqs_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic dqs_i,
  output logic edge_o
);

  logic smp_q;
  logic prv_q;
  logic smp_en;

  assign smp_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      prv_q <= 1'b0;
    end else if (smp_en) begin
      smp_q <= dqs_i;
      prv_q <= smp_q;
    end
  end

  assign edge_o = smp_q ^ prv_q;

endmodule

// File: rtl/dqs_lat_timer.sv
// Down-counter for the masking window. Reports expiry on its last count.
module dqs_lat_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [LAT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             expire_o
);

  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (load_i)
      cnt_d = val_i;
    else if (dec_i && (cnt_q != '0))
      cnt_d = cnt_q - ONE;
  end

  assign cnt_en = clr_i | load_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == ONE);

endmodule

// File: rtl/dqs_beat_counter.sv
// Holds the burst length captured at read issue and counts captured edges.
module dqs_beat_counter #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [BL_W-1:0] bl_i,
  input  logic            inc_i,
  output logic            last_o
);

  localparam logic [BL_W-1:0] ONE = BL_W'(1);

  logic [BL_W-1:0] cnt_q;
  logic [BL_W-1:0] cnt_d;
  logic [BL_W-1:0] bl_q;
  logic [BL_W-1:0] nxt;
  logic            cnt_en;

  assign nxt = cnt_q + ONE;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || load_i)
      cnt_d = '0;
    else if (inc_i)
      cnt_d = nxt;
  end

  assign cnt_en = clr_i | load_i | inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bl_q <= '0;
    else if (load_i)
      bl_q <= bl_i;
  end

  // Wraps naturally: a stored length of zero completes after 2^BL_W edges.
  assign last_o = (nxt == bl_q);

endmodule

// File: rtl/dqs_read_gate.sv
module dqs_read_gate
  import dqs_gate_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int BL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_issue,
  input  logic             wr_active,
  input  logic [LAT_W-1:0] lat_cfg,
  input  logic [BL_W-1:0]  burst_len,
  input  logic             dqs_in,
  output logic             cap_pulse,
  output logic             busy,
  output logic             rd_done
);

  gate_state_e st_q;
  gate_state_e st_d;

  logic strobe_edge;
  logic tmr_clr, tmr_load, tmr_dec, tmr_expire;
  logic bc_clr, bc_load, bc_inc, bc_last;

  dqs_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .dqs_i  (dqs_in),
    .edge_o (strobe_edge)
  );

  dqs_lat_timer #(.LAT_W(LAT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .load_i   (tmr_load),
    .val_i    (lat_cfg),
    .dec_i    (tmr_dec),
    .expire_o (tmr_expire)
  );

  dqs_beat_counter #(.BL_W(BL_W)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (bc_clr),
    .load_i (bc_load),
    .bl_i   (burst_len),
    .inc_i  (bc_inc),
    .last_o (bc_last)
  );

  // Next-state and control decode
  always_comb begin
    st_d     = st_q;
    tmr_clr  = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    bc_clr   = 1'b0;
    bc_load  = 1'b0;
    bc_inc   = 1'b0;
    if (wr_active) begin
      st_d    = ST_IDLE;
      tmr_clr = 1'b1;
      bc_clr  = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (rd_issue) begin
            bc_load = 1'b1;
            if (lat_cfg == '0) begin
              st_d = ST_CAPT;
            end else begin
              tmr_load = 1'b1;
              st_d     = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          tmr_dec = 1'b1;
          if (tmr_expire)
            st_d = ST_CAPT;
        end
        ST_CAPT: begin
          if (strobe_edge) begin
            bc_inc = 1'b1;
            if (bc_last)
              st_d = ST_DONE;
          end
        end
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_IDLE;
    else
      st_q <= st_d;
  end

  assign busy      = (st_q != ST_IDLE);
  assign rd_done   = (st_q == ST_DONE);
  assign cap_pulse = (st_q == ST_CAPT) && strobe_edge;

endmodule

// File: rtl/dqs_read_gate_chk.sv
module dqs_read_gate_chk #(
  parameter int LAT_W = 4,
  parameter int BL_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_issue,
  input logic             wr_active,
  input logic [LAT_W-1:0] lat_cfg,
  input logic [BL_W-1:0]  burst_len,
  input logic             cap_pulse,
  input logic             busy,
  input logic             rd_done
);

  localparam logic [BL_W:0]  BL_MAX  = {1'b1, {BL_W{1'b0}}};
  localparam logic [LAT_W-1:0] W_ONE = LAT_W'(1);
  localparam logic [BL_W:0]  B_ONE   = (BL_W+1)'(1);

  logic             accept;
  logic [LAT_W-1:0] win_q;
  logic [BL_W:0]    beats_q;
  logic [BL_W:0]    blen_q;

  assign accept = rd_issue && !busy && !wr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      beats_q <= '0;
      blen_q  <= '0;
    end else begin
      if (wr_active) begin
        win_q   <= '0;
        beats_q <= '0;
      end else if (accept) begin
        win_q   <= lat_cfg;
        beats_q <= '0;
        blen_q  <= (burst_len == '0) ? BL_MAX : {1'b0, burst_len};
      end else begin
        if (win_q != '0)
          win_q <= win_q - W_ONE;
        if (cap_pulse)
          beats_q <= beats_q + B_ONE;
      end
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r3_masked_window: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> (win_q == '0));

  a_r5_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> (beats_q < blen_q));

  a_r5_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (beats_q == blen_q));

  a_r5_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (!busy && !rd_done));

  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done && !wr_active) |=> busy);

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> (!busy && !cap_pulse));

  a_r10_cap_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> (busy && !rd_done));

endmodule

bind dqs_read_gate dqs_read_gate_chk #(.LAT_W(LAT_W), .BL_W(BL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_issue  (rd_issue),
  .wr_active (wr_active),
  .lat_cfg   (lat_cfg),
  .burst_len (burst_len),
  .cap_pulse (cap_pulse),
  .busy      (busy),
  .rd_done   (rd_done)
);

// File: tb/dqs_read_gate_bench.sv
module dqs_read_gate_bench;

  localparam int LAT_W = 4;
  localparam int BL_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_issue = 1'b0;
  logic             wr_active = 1'b0;
  logic [LAT_W-1:0] lat_cfg = '0;
  logic [BL_W-1:0]  burst_len = '0;
  logic             dqs_in = 1'b0;
  logic             cap_pulse, busy, rd_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dqs_read_gate #(.LAT_W(LAT_W), .BL_W(BL_W)) u_dqs_read_gate (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .wr_active(wr_active),
    .lat_cfg(lat_cfg), .burst_len(burst_len), .dqs_in(dqs_in),
    .cap_pulse(cap_pulse), .busy(busy), .rd_done(rd_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Starts at a negedge. Issues a read with latency lat and burst bl_n,
  // toggles the strobe so edges are visible in cycles s .. s+n-1.
  task automatic run_read(input int lat, input int bl_n, input int s, input int n,
                          input bit stuck);
    int first, done_c, horizon;
    first   = (s > lat) ? s : lat;
    done_c  = ((s + n - first) >= bl_n) ? first + bl_n : -1;
    horizon = (done_c >= 0) ? done_c + 2 : s + n + 6;
    lat_cfg   = LAT_W'(lat);
    burst_len = BL_W'(bl_n % (1 << BL_W));
    rd_issue  = 1'b1;
    if (s == 0 && n > 0) dqs_in = ~dqs_in;
    @(negedge clk);
    for (int c = 0; c < horizon; c++) begin
      int ecap, edone, ebusy;
      if (c == 0) begin
        // R8 / R9: second issue pulse and new settings while busy
        lat_cfg   = ~LAT_W'(lat);
        burst_len = BL_W'(1);
      end
      if (c == 1) rd_issue = 1'b0;
      ecap  = (c >= first && c < s + n && (c - first) < bl_n) ? 1 : 0;
      edone = (c == done_c) ? 1 : 0;
      ebusy = (done_c < 0 || c <= done_c) ? 1 : 0;
      chk("R3/R4", "cap_pulse", int'(cap_pulse), ecap);
      chk(stuck ? "R6" : "R5", "rd_done", int'(rd_done), edone);
      chk(stuck ? "R6" : "R5", "busy", int'(busy), ebusy);
      if (c + 1 >= s && c + 1 < s + n) dqs_in = ~dqs_in;
      @(negedge clk);
    end
    rd_issue = 1'b0;
    if (stuck) begin
      wr_active = 1'b1;
      dqs_in = ~dqs_in;
      @(negedge clk);
      wr_active = 1'b0;
      chk("R7", "busy after write", int'(busy), 0);
      chk("R7", "cap after write", int'(cap_pulse), 0);
      @(negedge clk);
      chk("R7", "busy idle", int'(busy), 0);
    end
  endtask

  initial begin : main
    // R1: reset state
    @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "cap in reset", int'(cap_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "cap_pulse", int'(cap_pulse), 0);
    chk("R1", "rd_done", int'(rd_done), 0);

    // R10: strobe toggling while idle
    for (int k = 0; k < 4; k++) begin
      dqs_in = ~dqs_in;
      @(negedge clk);
      chk("R10", "cap idle", int'(cap_pulse), 0);
    end
    @(negedge clk);

    // R7: write overrides simultaneous issue
    lat_cfg = 4'd2; burst_len = 4'd2; rd_issue = 1'b1; wr_active = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0; wr_active = 1'b0;
    chk("R7", "issue under write", int'(busy), 0);

    // R7: write during the masking window, later edges ignored
    lat_cfg = 4'd8; rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
    chk("R2", "accepted", int'(busy), 1);
    @(negedge clk);
    wr_active = 1'b1;
    @(negedge clk);
    wr_active = 1'b0;
    for (int k = 0; k < 12; k++) begin
      dqs_in = ~dqs_in;
      @(negedge clk);
      chk("R7", "cleared busy", int'(busy), 0);
      chk("R7", "cleared cap", int'(cap_pulse), 0);
    end
    @(negedge clk);

    // Sweep latency, burst length and strobe start (R2..R5, R8, R9)
    for (int lat = 0; lat < 10; lat++) begin
      for (int bi = 0; bi < 5; bi++) begin
        int bl_n;
        bl_n = (bi == 4) ? 16 : bi + 1;
        for (int si = 0; si < 3; si++) begin
          int s, first;
          s = (si == 0) ? 0 : (si == 1) ? lat : lat + 3;
          first = (s > lat) ? s : lat;
          run_read(lat, bl_n, s, (first - s) + bl_n + 2, 1'b0);
        end
      end
    end

    // R6: short bursts leave the block waiting until a write
    for (int lat = 0; lat < 7; lat += 3) begin
      run_read(lat, 2, 0, lat + 1, 1'b1);
      run_read(lat, 4, lat, 3, 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule